// File: doc/BRIEF.md
# Deferred-Enable Program Interrupt Unit

This block is the single-level program interrupt logic for a small word-oriented processor. It sits on the I/O side of the machine rather than in the core. The processor gives it three signals: a strobe at the end of every instruction, and decoded strobes for the "interrupts on" and "interrupts off" instructions that arrive together with that end-of-instruction strobe. The block holds one enable flag, and it also drives that flag to a front-panel lamp.

Requests are level signals from devices, such as a real-time clock flag, and are merged with an OR. A request is looked at only at an instruction boundary. Turning interrupts on is deferred. The boundary at which the enabling instruction itself completes never produces a grant, so an enable followed at once by a disable never services a request, even one that was already waiting. When the block grants, it raises a one-cycle grant. During that cycle it presents the save address, where the processor stores its program counter, and the vector address, from which it fetches next. The enable flag drops in the same edge, so the handler starts with interrupts off.

Top module: `irq_defer_unit`

## Requirements
- R1: While reset is asserted and after it is released, grant_o is 0, en_lamp_o is 0, and save_addr_o and vec_addr_o are 0.
- R2: A boundary (instr_done_i=1) with ion_i=1 and iof_i=0 sets the enable flag, and en_lamp_o reads 1 from the next clock edge.
- R3: A boundary with iof_i=1 clears the enable flag at the next edge, whatever ion_i is. The disable wins when both strobes coincide.
- R4: ion_i and iof_i have no effect in a cycle where instr_done_i=0. en_lamp_o does not change at such an edge.
- R5: The boundary that carries ion_i never produces a grant, even with a request present. A disable at the very next boundary therefore leaves a pending request unserviced.
- R6: A boundary with no strobe, the enable flag set and any bit of req_i at 1 makes grant_o 1 for exactly the one cycle after that edge.
- R7: The edge that raises grant_o also clears the enable flag, so en_lamp_o is 0 while grant_o is 1.
- R8: While grant_o is 1, save_addr_o equals SAVE_LOC (default 0) and vec_addr_o equals VEC_LOC (default 1). In every other cycle both are 0.
- R9: No grant is issued while the enable flag is clear, or when all bits of req_i are 0 at the boundary.
- R10: Requests are sampled only at boundaries. A request that is high between boundaries but low at the boundary itself produces no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done_i | input | 1 | Instruction boundary strobe |
| ion_i | input | 1 | Decoded interrupts-on instruction, valid with instr_done_i |
| iof_i | input | 1 | Decoded interrupts-off instruction, valid with instr_done_i |
| req_i | input | NUM_REQ | Level interrupt requests, one per device flag |
| grant_o | output | 1 | One-cycle interrupt grant to the processor |
| save_addr_o | output | ADDR_W | Location that receives the program counter, valid with grant_o |
| vec_addr_o | output | ADDR_W | Location of the next fetch, valid with grant_o |
| en_lamp_o | output | 1 | Interrupt-enable state for the panel lamp |

## Verification
Every result of the block is due exactly one rising edge after the boundary that caused it. The enable change, the grant pulse and the two addresses all come from registers loaded on that edge. The grant's fall is due one edge later again. The bench drives its inputs on the falling edge. It runs a reference model on the rising edge from the same inputs and compares all four outputs with that model at every falling edge. Directed checks read the outputs 1 ns after the edge that the stimulus belongs to, so each one looks at the cycle in which its result is first due.

// File: rtl/irq_defer_pkg.sv
`timescale 1ns/1ps
package irq_defer_pkg;

  // Action decided at an instruction boundary
  typedef enum logic [1:0] {
    BA_NONE = 2'd0,
    BA_ON   = 2'd1,
    BA_OFF  = 2'd2,
    BA_TAKE = 2'd3
  } bnd_act_e;

endpackage

// File: rtl/irq_bnd_decode.sv
`timescale 1ns/1ps
module irq_bnd_decode
  import irq_defer_pkg::*;
#(
  parameter int NUM_REQ = 4
) (
  input  logic               bnd_i,
  input  logic               ion_i,
  input  logic               iof_i,
  input  logic               en_i,
  input  logic [NUM_REQ-1:0] req_i,
  output bnd_act_e           act_o
);

  logic req_any;

  assign req_any = |req_i;

  // Priority: disable, then enable, then service.
  // The enabling instruction's own boundary never services.
  always_comb begin
    act_o = BA_NONE;
    if (bnd_i) begin
      if (iof_i) begin
        act_o = BA_OFF;
      end else if (ion_i) begin
        act_o = BA_ON;
      end else if (en_i && req_any) begin
        act_o = BA_TAKE;
      end
    end
  end

endmodule

// File: rtl/irq_enable_reg.sv
`timescale 1ns/1ps
module irq_enable_reg
  import irq_defer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bnd_act_e act_i,
  output logic     en_o
);

  logic en_d;
  logic en_q;
  logic en_ld;

  // clock enable: only a boundary action touches the flag
  assign en_ld = (act_i != BA_NONE);

  always_comb begin
    en_d = en_q;
    case (act_i)
      BA_ON:   en_d = 1'b1;
      BA_OFF:  en_d = 1'b0;
      BA_TAKE: en_d = 1'b0;
      default: en_d = en_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ld) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/irq_grant_reg.sv
`timescale 1ns/1ps
module irq_grant_reg
  import irq_defer_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int SAVE_LOC = 0,
  parameter int VEC_LOC  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bnd_act_e          act_i,
  output logic              grant_o,
  output logic [ADDR_W-1:0] save_o,
  output logic [ADDR_W-1:0] vec_o
);

  localparam logic [ADDR_W-1:0] SAVE_A = SAVE_LOC[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] VEC_A  = VEC_LOC[ADDR_W-1:0];

  logic              gnt_d;
  logic              gnt_q;
  logic [ADDR_W-1:0] save_d;
  logic [ADDR_W-1:0] save_q;
  logic [ADDR_W-1:0] vec_d;
  logic [ADDR_W-1:0] vec_q;

  always_comb begin
    gnt_d  = (act_i == BA_TAKE);
    save_d = gnt_d ? SAVE_A : '0;
    vec_d  = gnt_d ? VEC_A  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= 1'b0;
      save_q <= '0;
      vec_q  <= '0;
    end else begin
      gnt_q  <= gnt_d;
      save_q <= save_d;
      vec_q  <= vec_d;
    end
  end

  assign grant_o = gnt_q;
  assign save_o  = save_q;
  assign vec_o   = vec_q;

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_q |=> !gnt_q); // R6

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_q |-> (save_q == '0 && vec_q == '0)); // R8

endmodule

// File: rtl/irq_defer_unit.sv
`timescale 1ns/1ps
module irq_defer_unit
  import irq_defer_pkg::*;
#(
  parameter int NUM_REQ  = 4,
  parameter int ADDR_W   = 13,
  parameter int SAVE_LOC = 0,
  parameter int VEC_LOC  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done_i,
  input  logic               ion_i,
  input  logic               iof_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               grant_o,
  output logic [ADDR_W-1:0]  save_addr_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               en_lamp_o
);

  bnd_act_e act;
  logic     en;

  irq_bnd_decode #(.NUM_REQ(NUM_REQ)) u_dec (
    .bnd_i (instr_done_i),
    .ion_i (ion_i),
    .iof_i (iof_i),
    .en_i  (en),
    .req_i (req_i),
    .act_o (act)
  );

  irq_enable_reg u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .act_i (act),
    .en_o  (en)
  );

  irq_grant_reg #(
    .ADDR_W   (ADDR_W),
    .SAVE_LOC (SAVE_LOC),
    .VEC_LOC  (VEC_LOC)
  ) u_gnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .grant_o (grant_o),
    .save_o  (save_addr_o),
    .vec_o   (vec_addr_o)
  );

  assign en_lamp_o = en;

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done_i && iof_i) |=> !en_lamp_o); // R3

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done_i |=> $stable(en_lamp_o)); // R4

  AST_NO_GRANT_AT_ION: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done_i && ion_i) |=> !grant_o); // R5

  AST_GRANT_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !en_lamp_o); // R7

  AST_NO_GRANT_UNSAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_done_i && (|req_i)) |=> !grant_o); // R10

  AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lamp_o |=> !grant_o); // R9

endmodule

// File: tb/tb_irq_defer_unit.sv
`timescale 1ns/1ps
module tb_irq_defer_unit;

  localparam int NUM_REQ = 4;
  localparam int ADDR_W  = 13;

  logic               clk;
  logic               rst_n;
  logic               bnd;
  logic               ion;
  logic               iof;
  logic [NUM_REQ-1:0] req;
  logic               grant;
  logic [ADDR_W-1:0]  save_a;
  logic [ADDR_W-1:0]  vec_a;
  logic               lamp;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  // reference model state
  logic  m_en;
  logic  m_gnt;
  string m_tag_lamp;
  string m_tag_gnt;

  irq_defer_unit #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_done_i (bnd),
    .ion_i        (ion),
    .iof_i        (iof),
    .req_i        (req),
    .grant_o      (grant),
    .save_addr_o  (save_a),
    .vec_addr_o   (vec_a),
    .en_lamp_o    (lamp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural model: one update per rising edge from the bench's own inputs
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en       <= 1'b0;
      m_gnt      <= 1'b0;
      m_tag_lamp <= "R1";
      m_tag_gnt  <= "R1";
    end else begin
      m_gnt <= 1'b0;
      if (!bnd) begin
        m_tag_lamp <= "R4";
        m_tag_gnt  <= (req != 0) ? "R10" : "R9";
      end else if (iof) begin
        m_en       <= 1'b0;
        m_tag_lamp <= "R3";
        m_tag_gnt  <= "R9";
      end else if (ion) begin
        m_en       <= 1'b1;
        m_tag_lamp <= "R2";
        m_tag_gnt  <= "R5";
      end else if (m_en && (req != 0)) begin
        m_en       <= 1'b0;
        m_gnt      <= 1'b1;
        m_tag_lamp <= "R7";
        m_tag_gnt  <= "R6";
      end else begin
        m_tag_lamp <= "R4";
        m_tag_gnt  <= "R9";
      end
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(grant == m_gnt, m_tag_gnt, "grant", int'(grant), int'(m_gnt));
      chk(lamp == m_en, m_tag_lamp, "lamp", int'(lamp), int'(m_en));
      chk(save_a == '0, "R8", "save addr", int'(save_a), 0);
      chk(vec_a == (m_gnt ? 13'd1 : 13'd0), "R8", "vector addr", int'(vec_a),
          m_gnt ? 1 : 0);
    end
  end

  // Apply one cycle of inputs; return 1 ns after the edge that samples them
  task automatic drive(input logic b, input logic on, input logic off,
                       input logic [NUM_REQ-1:0] r);
    @(negedge clk);
    bnd = b; ion = on; iof = off; req = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #80000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bnd = 0; ion = 0; iof = 0; req = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(grant == 1'b0, "R1", "grant in reset", int'(grant), 0);
    chk(lamp == 1'b0, "R1", "lamp in reset", int'(lamp), 0);
    chk(save_a == '0 && vec_a == '0, "R1", "addrs in reset", int'(vec_a), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    drive(0, 0, 0, '0);
    chk(lamp == 1'b0 && grant == 1'b0, "R1", "after release", int'(lamp), 0);

    // R2: enable at boundary
    drive(1, 1, 0, '0);
    chk(lamp == 1'b1, "R2", "lamp after on", int'(lamp), 1);
    // R9: enabled but no request
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, '0);
      chk(grant == 1'b0, "R9", "grant without request", int'(grant), 0);
    end
    // R6, R7, R8: service
    drive(1, 0, 0, 4'b0010);
    chk(grant == 1'b1, "R6", "grant on request", int'(grant), 1);
    chk(lamp == 1'b0, "R7", "lamp at grant", int'(lamp), 1'b0);
    chk(save_a == 13'd0, "R8", "save addr", int'(save_a), 0);
    chk(vec_a == 13'd1, "R8", "vector addr", int'(vec_a), 1);
    drive(1, 0, 0, 4'b0010);
    chk(grant == 1'b0, "R6", "grant single cycle", int'(grant), 0);
    chk(vec_a == 13'd0, "R8", "vector idle", int'(vec_a), 0);
    chk(grant == 1'b0, "R9", "no grant while disabled", int'(grant), 0);

    // R5: pending request, on then off at once
    drive(1, 1, 0, 4'b1000);
    chk(grant == 1'b0, "R5", "no grant at on boundary", int'(grant), 0);
    drive(1, 0, 1, 4'b1000);
    chk(grant == 1'b0 && lamp == 1'b0, "R5", "on-off skips request", int'(grant), 0);
    drive(1, 0, 0, 4'b1000);
    chk(grant == 1'b0, "R5", "still no grant after off", int'(grant), 0);

    // R4: strobes without a boundary
    drive(0, 1, 0, 4'b0001);
    chk(lamp == 1'b0, "R4", "on ignored off-boundary", int'(lamp), 0);
    drive(1, 0, 0, 4'b0001);
    chk(grant == 1'b0, "R4", "no grant after ignored on", int'(grant), 0);
    drive(1, 1, 0, '0);
    drive(0, 0, 1, '0);
    chk(lamp == 1'b1, "R4", "off ignored off-boundary", int'(lamp), 1);

    // R3: both strobes together
    drive(1, 1, 1, '0);
    chk(lamp == 1'b0, "R3", "off wins", int'(lamp), 0);

    // R10: request only between boundaries
    drive(1, 1, 0, '0);
    drive(0, 0, 0, 4'b0100);
    drive(0, 0, 0, 4'b0100);
    drive(1, 0, 0, '0);
    chk(grant == 1'b0, "R10", "unsampled request", int'(grant), 0);
    drive(0, 0, 0, 4'b0100);
    drive(1, 0, 0, 4'b0100);
    chk(grant == 1'b1, "R6", "grant after multi-cycle instr", int'(grant), 1);
    drive(0, 0, 0, '0);

    // mixed traffic, checked by the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 16;
      drive(($urandom % 3) != 0, r < 3, r == 3 || r == 15,
            (($urandom % 2) != 0) ? NUM_REQ'($urandom) : '0);
    end

    drive(0, 0, 0, '0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule